// File: doc/BRIEF.md
# Background Patrol Scrub Scheduler

This block decides when a memory system should scrub. It has three channels: one for the level-one data cache, one for the level-two cache and one for main memory. Each channel keeps a 5-bit rate code. When the code is nonzero, the channel waits an interval of `2^code` time-base ticks and then raises a request to scrub one 64-byte line. The request stays up until the consumer acknowledges it. A tick lasts `TICK_CYC` clock cycles. With a 20 ns tick, code 8 gives one line every 5.12 us and code 13 gives one line every 163.84 us.

The main-memory channel also keeps a line address. Software loads this address through a low register and a high register, normally with the node's memory base, before it enables scrubbing. The address steps by one line (64 bytes) after each acknowledged scrub. When redirect mode is enabled, a one-cycle redirect pulse sends the next scrub to a supplied line. After that scrub, sequential stepping continues from the saved address. An interleave input forces the main-memory channel off whatever its rate code, and a status bit reports that the channel is off.

Software uses a small register port. Writes are synchronous and reads are combinational. Register selects:
- 0: rate codes.
- 1: low address.
- 2: high address.
- 3: status.

Top module: `scrub_patrol`

## Requirements
- R1: After reset, all rate codes read 0, no request is raised, the memory line address is 0, redirect mode is off, and `dram_off` is 1.
- R2: A channel whose rate code is 0 never raises a new request.
- R3: Rate code fields sit in the rate register at bits [4:0] (L1), [12:8] (L2) and [20:16] (memory). With nonzero code c, a channel's request rises exactly `2^c * TICK_CYC` cycles after the write to the rate register.
- R4: A request stays high until its acknowledge is sampled with it. The interval does not advance while the request is pending. The next request rises exactly one interval after the acknowledge edge, however long the acknowledge was delayed.
- R5: Any write to the rate register restarts all three interval counts from zero.
- R6: A code written above 22 is stored and read back as 22. Codes up to 22 are stored unchanged.
- R7: While `interleave_en` is 1, the memory channel raises no request and both `dram_off` and status bit 0 read 1. The cache channels are unaffected. When `interleave_en` drops, the memory interval starts from zero.
- R8: The low register writes line address bits [25:0] from data bits [31:6] and the redirect enable from bit 0. The high register writes the upper line bits from its low data bits. Both read back in the same layout.
- R9: Each acknowledged memory scrub with no redirect pending advances the line address by one, carrying from the low field into the high field.
- R10: With redirect enabled, a `redir_valid` pulse makes `dram_line` show `redir_line` from the next cycle. The next acknowledged memory scrub consumes the redirect. After it, the saved sequential address shows again, unchanged.
- R11: A `redir_valid` pulse while redirect mode is off has no effect on `dram_line`.
- R12: The three channels time independently. With different codes set together, each rises at its own interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 rates, 1 low address, 2 high address, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_sel`, combinational |
| interleave_en | input | 1 | Memory is node-interleaved; forces the memory channel off |
| scrub_req | output | 3 | Requests: bit 0 L1, bit 1 L2, bit 2 memory |
| scrub_ack | input | 3 | Acknowledges, same bit order |
| redir_valid | input | 1 | One-cycle redirect pulse |
| redir_line | input | LINE_W | Redirect target line address |
| dram_line | output | LINE_W | Line address of the next memory scrub |
| dram_off | output | 1 | Memory scrubbing is off (code 0 or interleaved) |

## Verification
The assertions assume the following about the inputs:
- `scrub_ack` is raised only while the matching request is high.
- Register writes and redirect pulses last a single cycle.
- Rate-register writes do not arrive every cycle while an interval is being measured.

The bench drives every input at the falling edge and holds each strobe for exactly one cycle. It acknowledges only after it has seen the request. It leaves the register port idle while it counts cycles to a request edge. It also uses a two-cycle tick, so both the prescaler and the tick counter take part in every measured interval.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    localparam int CODE_W   = 5;
    localparam int MAX_CODE = 22;
    localparam int CH_N     = 3;
    localparam int CH_L1    = 0;
    localparam int CH_L2    = 1;
    localparam int CH_MEM   = 2;
    localparam int LO_W     = 26;

    typedef enum logic [1:0] {
        SEL_RATE = 2'd0,
        SEL_ALO  = 2'd1,
        SEL_AHI  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] c);
        return (c > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : c;
    endfunction
endpackage

// File: rtl/scrub_rate_timer.sv
module scrub_rate_timer #(
    parameter int TICK_CYC = 20,
    parameter int CODE_W   = 5,
    parameter int MAX_CODE = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              enable_i,
    input  logic              restart_i,
    input  logic              ack_i,
    output logic              req_o
);
    localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam int CNT_W = MAX_CODE;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             req;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim;
    logic             tick;

    always_comb begin
        span = (CNT_W+1)'(1) << code_i;
        lim  = CNT_W'(span - 1'b1);
        tick = (st_q.pre == PRE_W'(TICK_CYC - 1));
        st_d = st_q;
        if (st_q.req && ack_i) st_d.req = 1'b0;
        if (restart_i || !enable_i) begin
            st_d.pre = '0;
            st_d.cnt = '0;
        end else if (!st_q.req) begin
            if (tick) begin
                st_d.pre = '0;
                if (st_q.cnt == lim) begin
                    st_d.req = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);
    assert_count_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> $stable(st_q.cnt));
    assert_no_rise_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(enable_i));
    assert_code_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code_i <= CODE_W'(MAX_CODE));
endmodule

// File: rtl/scrub_line_addr.sv
module scrub_line_addr #(
    parameter int LINE_W = 34,
    parameter int LO_W   = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr_i,
    input  logic              hi_wr_i,
    input  logic [31:0]       wdata_i,
    input  logic              step_i,
    input  logic              redir_valid_i,
    input  logic [LINE_W-1:0] redir_line_i,
    output logic [LINE_W-1:0] seq_o,
    output logic              redir_en_o,
    output logic [LINE_W-1:0] line_o
);
    localparam int HI_W = LINE_W - LO_W;

    typedef struct packed {
        logic [LINE_W-1:0] seq;
        logic [LINE_W-1:0] tgt;
        logic              redir_en;
        logic              pend;
    } addr_t;

    addr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (st_q.pend) st_d.pend = 1'b0;
            else           st_d.seq  = st_q.seq + 1'b1;
        end
        if (lo_wr_i) begin
            st_d.seq[LO_W-1:0] = wdata_i[31:6];
            st_d.redir_en      = wdata_i[0];
        end
        if (hi_wr_i) st_d.seq[LINE_W-1:LO_W] = wdata_i[HI_W-1:0];
        if (redir_valid_i && st_q.redir_en) begin
            st_d.pend = 1'b1;
            st_d.tgt  = redir_line_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seq_o      = st_q.seq;
    assign redir_en_o = st_q.redir_en;
    assign line_o     = st_q.pend ? st_q.tgt : st_q.seq;

    assert_seq_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !st_q.pend && !lo_wr_i && !hi_wr_i) |=> (seq_o == $past(seq_o) + 1'b1));
    assert_redirect_keeps_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && st_q.pend && !lo_wr_i && !hi_wr_i) |=> $stable(seq_o));
    assert_redirect_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.redir_en && !st_q.pend && !lo_wr_i) |=> !st_q.pend);
endmodule

// File: rtl/scrub_patrol.sv
module scrub_patrol
    import scrub_pkg::*;
#(
    parameter int TICK_CYC = 20,
    parameter int ADDR_W   = 40,
    parameter int LINE_W   = ADDR_W - 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              interleave_en,
    output logic [CH_N-1:0]   scrub_req,
    input  logic [CH_N-1:0]   scrub_ack,
    input  logic              redir_valid,
    input  logic [LINE_W-1:0] redir_line,
    output logic [LINE_W-1:0] dram_line,
    output logic              dram_off
);
    typedef struct packed {
        logic [CH_N-1:0][CODE_W-1:0] code;
    } rate_t;

    rate_t             st_d, st_q;
    logic              rate_wr;
    logic [CH_N-1:0]   ch_en;
    logic [LINE_W-1:0] seq_line;
    logic              redir_en;

    assign rate_wr = reg_wr && (reg_sel == SEL_RATE);

    always_comb begin
        st_d = st_q;
        if (rate_wr) begin
            for (int i = 0; i < CH_N; i++)
                st_d.code[i] = sat_code(reg_wdata[8*i +: CODE_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dram_off = interleave_en || (st_q.code[CH_MEM] == '0);

    generate
        for (genvar g = 0; g < CH_N; g++) begin : g_ch
            if (g == CH_MEM) begin : g_mem_en
                assign ch_en[g] = !dram_off;
            end else begin : g_cache_en
                assign ch_en[g] = (st_q.code[g] != '0);
            end
            scrub_rate_timer #(
                .TICK_CYC(TICK_CYC),
                .CODE_W  (CODE_W),
                .MAX_CODE(MAX_CODE)
            ) u_tmr (
                .clk      (clk),
                .rst_n    (rst_n),
                .code_i   (st_q.code[g]),
                .enable_i (ch_en[g]),
                .restart_i(rate_wr),
                .ack_i    (scrub_ack[g]),
                .req_o    (scrub_req[g])
            );
        end
    endgenerate

    scrub_line_addr #(
        .LINE_W(LINE_W),
        .LO_W  (LO_W)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .lo_wr_i      (reg_wr && (reg_sel == SEL_ALO)),
        .hi_wr_i      (reg_wr && (reg_sel == SEL_AHI)),
        .wdata_i      (reg_wdata),
        .step_i       (scrub_req[CH_MEM] && scrub_ack[CH_MEM]),
        .redir_valid_i(redir_valid),
        .redir_line_i (redir_line),
        .seq_o        (seq_line),
        .redir_en_o   (redir_en),
        .line_o       (dram_line)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_RATE: begin
                for (int i = 0; i < CH_N; i++)
                    reg_rdata[8*i +: CODE_W] = st_q.code[i];
            end
            SEL_ALO:  reg_rdata = {seq_line[LO_W-1:0], 5'b0, redir_en};
            SEL_AHI:  reg_rdata = 32'(seq_line[LINE_W-1:LO_W]);
            default:  reg_rdata = {31'b0, dram_off};
        endcase
    end

    assert_interleave_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scrub_req[CH_MEM]) |-> !$past(interleave_en));
endmodule

// File: tb/tb_scrub_patrol.sv
module tb_scrub_patrol;
    localparam int TICK   = 2;
    localparam int LINE_W = 34;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              interleave_en = 1'b0;
    logic [2:0]        scrub_req;
    logic [2:0]        scrub_ack = '0;
    logic              redir_valid = 1'b0;
    logic [LINE_W-1:0] redir_line = '0;
    logic [LINE_W-1:0] dram_line;
    logic              dram_off;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    scrub_patrol #(.TICK_CYC(TICK), .ADDR_W(40)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .interleave_en(interleave_en),
        .scrub_req(scrub_req), .scrub_ack(scrub_ack), .redir_valid(redir_valid),
        .redir_line(redir_line), .dram_line(dram_line), .dram_off(dram_off)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic ack(input logic [2:0] m);
        @(negedge clk);
        scrub_ack = m;
        @(negedge clk);
        scrub_ack = '0;
    endtask

    task automatic wait_req(input int ch, input int lim, output int k);
        k = 0;
        while (!scrub_req[ch] && k <= lim) begin
            @(negedge clk);
            k++;
        end
        if (k > lim) k = -1;
    endtask

    function automatic logic [31:0] rate_word(input int c0, input int c1, input int c2);
        return 32'(c0) | (32'(c1) << 8) | (32'(c2) << 16);
    endfunction

    initial begin
        logic [31:0]       rv;
        int                k;
        logic [LINE_W-1:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(2'd0, rv);
        chk(rv == 0, "R1 rates", rv, 0);
        chk(scrub_req == 0, "R1 req", scrub_req, 0);
        chk(dram_line == 0, "R1 line", dram_line, 0);
        rd(2'd1, rv);
        chk(rv == 0, "R1 low reg", rv, 0);
        chk(dram_off == 1, "R1 dram_off", dram_off, 1);

        // R3 / R4 sweep over channels and codes
        for (int ch = 0; ch < 3; ch++) begin
            for (int c = 1; c <= 7; c++) begin
                wr(2'd0, 32'(c) << (8 * ch));
                wait_req(ch, 2000, k);
                chk(k == (1 << c) * TICK, $sformatf("R3 ch%0d code%0d", ch, c), k, (1 << c) * TICK);
                repeat (3) @(negedge clk);
                chk(scrub_req[ch] == 1, "R4 held", scrub_req[ch], 1);
                ack(3'(1 << ch));
                wait_req(ch, 2000, k);
                chk(k == (1 << c) * TICK, $sformatf("R4 rearm ch%0d code%0d", ch, c), k, (1 << c) * TICK);
                ack(3'(1 << ch));
                wr(2'd0, 0);
            end
        end

        // R5 restart
        wr(2'd0, rate_word(4, 0, 0));
        repeat (20) @(negedge clk);
        wr(2'd0, rate_word(4, 0, 0));
        wait_req(0, 500, k);
        chk(k == 16 * TICK, "R5 restart", k, 16 * TICK);
        ack(3'b001);
        wr(2'd0, 0);

        // R6 saturation
        wr(2'd0, rate_word(31, 23, 22));
        rd(2'd0, rv);
        chk(rv == rate_word(22, 22, 22), "R6 sat", rv, rate_word(22, 22, 22));
        wr(2'd0, rate_word(21, 0, 17));
        rd(2'd0, rv);
        chk(rv == rate_word(21, 0, 17), "R6 pass", rv, rate_word(21, 0, 17));
        wr(2'd0, 0);

        // R2 disabled channels
        repeat (300) @(negedge clk);
        chk(scrub_req == 0, "R2 all off", scrub_req, 0);
        wr(2'd0, rate_word(0, 3, 0));
        repeat (100) @(negedge clk);
        chk(scrub_req == 3'b010, "R2 only ch1", scrub_req, 3'b010);
        ack(3'b010);
        wr(2'd0, 0);

        // R7 interleave
        interleave_en = 1'b1;
        wr(2'd0, rate_word(1, 1, 1));
        repeat (40) @(negedge clk);
        chk(scrub_req == 3'b011, "R7 mem blocked", scrub_req, 3'b011);
        chk(dram_off == 1, "R7 dram_off", dram_off, 1);
        rd(2'd3, rv);
        chk(rv == 1, "R7 status", rv, 1);
        interleave_en = 1'b0;
        wait_req(2, 100, k);
        chk(k == 2 * TICK, "R7 release", k, 2 * TICK);
        rd(2'd3, rv);
        chk(rv == 0, "R7 status clear", rv, 0);
        ack(3'b111);
        wr(2'd0, 0);

        // R12 independence
        wr(2'd0, rate_word(1, 2, 3));
        begin
            int t0 = -1, t1 = -1, t2 = -1;
            for (int i = 0; i <= 40; i++) begin
                if (scrub_req[0] && t0 < 0) t0 = i;
                if (scrub_req[1] && t1 < 0) t1 = i;
                if (scrub_req[2] && t2 < 0) t2 = i;
                @(negedge clk);
            end
            chk(t0 == 2 * TICK, "R12 ch0", t0, 2 * TICK);
            chk(t1 == 4 * TICK, "R12 ch1", t1, 4 * TICK);
            chk(t2 == 8 * TICK, "R12 ch2", t2, 8 * TICK);
        end
        wr(2'd0, 0);
        ack(3'b111);

        // R8 address load
        base = {8'h5A, 26'h3FFFFFE};
        wr(2'd1, {26'h3FFFFFE, 6'b0});
        wr(2'd2, 32'h5A);
        rd(2'd1, rv);
        chk(rv == 32'hFFFFFF80, "R8 low", rv, 32'hFFFFFF80);
        rd(2'd2, rv);
        chk(rv == 32'h5A, "R8 high", rv, 32'h5A);
        chk(dram_line == base, "R8 line", dram_line, base);

        // R9 stepping with carry
        wr(2'd0, rate_word(0, 0, 1));
        for (int i = 0; i < 4; i++) begin
            wait_req(2, 100, k);
            chk(dram_line == base + LINE_W'(i), "R9 step", dram_line, base + LINE_W'(i));
            ack(3'b100);
        end
        wr(2'd0, 0);
        rd(2'd2, rv);
        chk(rv == 32'h5B, "R9 carry high", rv, 32'h5B);
        rd(2'd1, rv);
        chk(rv == 32'h80, "R9 low", rv, 32'h80);

        // R11 redirect ignored when disabled
        @(negedge clk);
        redir_line = 34'h111; redir_valid = 1'b1;
        @(negedge clk);
        redir_valid = 1'b0;
        @(negedge clk);
        chk(dram_line == base + 4, "R11 ignored", dram_line, base + 4);

        // R10 redirect
        wr(2'd1, 32'h81);
        rd(2'd1, rv);
        chk(rv == 32'h81, "R10 enable bit", rv, 32'h81);
        @(negedge clk);
        redir_line = 34'h2ABC; redir_valid = 1'b1;
        @(negedge clk);
        redir_valid = 1'b0;
        chk(dram_line == 34'h2ABC, "R10 target", dram_line, 34'h2ABC);
        wr(2'd0, rate_word(0, 0, 1));
        wait_req(2, 100, k);
        chk(dram_line == 34'h2ABC, "R10 scrub target", dram_line, 34'h2ABC);
        ack(3'b100);
        chk(dram_line == base + 4, "R10 resume", dram_line, base + 4);
        wait_req(2, 100, k);
        ack(3'b100);
        chk(dram_line == base + 5, "R10 step after", dram_line, base + 5);
        wr(2'd0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule